// File: doc/BRIEF.md
# Serial Seven-Segment Scan Driver

This block lights a six-digit multiplexed seven-segment display whose segment and digit-select lines hang off a chain of two serial-in, parallel-out shift registers. It takes one 4-bit hexadecimal code per digit plus a decimal-point mask. It turns each code into a segment pattern and visits the digits one after another. For every digit it sends a 16-bit word over three wires: serial data, shift clock and latch. Which value reaches the display, and any binary-to-decimal conversion, are decided upstream.

A digit slot lasts `SLOT_CYC` system cycles. At the start of each slot the driver samples the inputs for the current digit and builds the word. It clocks the word out at one system-clock divided by `SCLK_DIV`, then raises the latch for one shift-clock period. The line stays quiet until the next slot begins. With a 50 MHz clock the defaults give a 12.5 MHz shift clock and about 1 kHz refresh per digit.

Parameters choose the segment polarity, the digit-select polarity and whether the stream goes out MSB-first or LSB-first. Both mistakes (wrong polarity, wrong bit order) give a blank or scrambled display, so these choices sit in this single module. `SLOT_CYC` must exceed `17*SCLK_DIV`.

Top module: `segscan_drv`

## Requirements
- R1: While `rst_n` is low, all three serial outputs are low. The first word latched after reset belongs to digit 0.
- R2: A code is turned into segments as {g,f,e,d,c,b,a} on bits 6..0 of the segment byte. The patterns are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 B:7C C:39 D:5E E:79 F:71 (hex, segment lit = 1 before polarity).
- R3: Bit 7 of the segment byte carries `dp_mask_i[i]` for digit i.
- R4: The digit-select byte is one-hot, with bit i set for digit i and bits NDIG..7 clear (before polarity).
- R5: The 16-bit word is {segment byte, select byte}. With `LSB_FIRST`=0, bit 15 is sent first and bit 0 last. With `LSB_FIRST`=1, the order is reversed.
- R6: `SEG_ON_LOW`=1 inverts all eight bits of the segment byte. `SEL_ON_LOW`=1 inverts all eight bits of the select byte.
- R7: Each bit takes `SCLK_DIV` cycles. The shift clock is low for the first half of those cycles and high for the second half. Data changes only while the shift clock is low.
- R8: After the 16th rising shift-clock edge, the latch is high for exactly `SCLK_DIV` cycles while the shift clock is low. Neither line is active for the rest of the slot.
- R9: Digits are visited in the order 0,1,..,NDIG-1 and then wrap to 0, one per `SLOT_CYC` cycles. A word starts leaving the block two cycles after its slot begins.
- R10: The inputs are sampled once, at the start of a slot. Changes made while a word is being shifted do not alter that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digits_i | input | NDIG*4 | Hex code per digit; digit i at bits 4i+3..4i |
| dp_mask_i | input | NDIG | Decimal point per digit |
| ser_data_o | output | 1 | Serial data to the register chain |
| ser_clk_o | output | 1 | Shift clock, chain samples on rising edge |
| ser_latch_o | output | 1 | Storage-register transfer pulse |

## Verification
Some properties are checked on every cycle. Data must hold still while the shift clock is high. Each high phase of the shift clock must have the right length. Exactly sixteen rising edges must come before every latch pulse, and the latch must have the right width and never overlap the shift clock. The digit index must only step forward by one, with wrap-around. Other behaviour needs the bench's scenarios: the segment table, decimal-point placement, one-hot select, polarity and bit-order variants, and the sampling of inputs at the start of a slot. For these, a modelled receiver rebuilds each latched word and compares it with the word expected for that slot, while the line waveform is compared cycle by cycle.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_SHIFT = 2'd1,
        MODE_LATCH = 2'd2
    } scan_mode_e;

    // Segment pattern {g,f,e,d,c,b,a}, lit = 1
    function automatic logic [6:0] hex_to_seg(input logic [3:0] code);
        logic [6:0] pat;
        case (code)
            4'h0: pat = 7'h3F;
            4'h1: pat = 7'h06;
            4'h2: pat = 7'h5B;
            4'h3: pat = 7'h4F;
            4'h4: pat = 7'h66;
            4'h5: pat = 7'h6D;
            4'h6: pat = 7'h7D;
            4'h7: pat = 7'h07;
            4'h8: pat = 7'h7F;
            4'h9: pat = 7'h6F;
            4'hA: pat = 7'h77;
            4'hB: pat = 7'h7C;
            4'hC: pat = 7'h39;
            4'hD: pat = 7'h5E;
            4'hE: pat = 7'h79;
            default: pat = 7'h71;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/segscan_sequencer.sv
module segscan_sequencer #(
    parameter int NDIG     = 6,
    parameter int SLOT_CYC = 8333,
    parameter int DIG_W    = (NDIG > 1) ? $clog2(NDIG) : 1,
    parameter int CNT_W    = $clog2(SLOT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DIG_W-1:0] dig_o,
    output logic             load_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DIG_W-1:0] dig;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == CNT_W'(SLOT_CYC - 1)) begin
            s_d.cnt = '0;
            s_d.dig = (s_q.dig == DIG_W'(NDIG - 1)) ? '0 : s_q.dig + 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dig_o  = s_q.dig;
    assign load_o = (s_q.cnt == '0);

endmodule

// File: rtl/segscan_glyph.sv
module segscan_glyph
    import segscan_pkg::*;
#(
    parameter int NDIG       = 6,
    parameter int DIG_W      = (NDIG > 1) ? $clog2(NDIG) : 1,
    parameter bit LSB_FIRST  = 1'b0,
    parameter bit SEG_ON_LOW = 1'b1,
    parameter bit SEL_ON_LOW = 1'b0
) (
    input  logic [NDIG*4-1:0] digits_i,
    input  logic [NDIG-1:0]   dp_mask_i,
    input  logic [DIG_W-1:0]  dig_i,
    output logic [WORD_W-1:0] word_o
);

    logic [3:0]        code;
    logic [BYTE_W-1:0] seg_raw, sel_raw, seg_pol, sel_pol;
    logic [WORD_W-1:0] natural_w;

    assign code    = digits_i[int'(dig_i)*4 +: 4];
    assign seg_raw = {dp_mask_i[dig_i], hex_to_seg(code)};

    for (genvar i = 0; i < BYTE_W; i++) begin : g_sel
        if (i < NDIG) begin : g_used
            assign sel_raw[i] = (dig_i == DIG_W'(i));
        end else begin : g_unused
            assign sel_raw[i] = 1'b0;
        end
    end

    assign seg_pol   = SEG_ON_LOW ? ~seg_raw : seg_raw;
    assign sel_pol   = SEL_ON_LOW ? ~sel_raw : sel_raw;
    assign natural_w = {seg_pol, sel_pol};

    // word_o[WORD_W-1] is the first bit on the line
    if (LSB_FIRST) begin : g_rev
        for (genvar k = 0; k < WORD_W; k++) begin : g_bit
            assign word_o[k] = natural_w[WORD_W-1-k];
        end
    end else begin : g_fwd
        assign word_o = natural_w;
    end

endmodule

// File: rtl/segscan_serializer.sv
module segscan_serializer
    import segscan_pkg::*;
#(
    parameter int SCLK_DIV = 4,
    parameter int PH_W     = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdat_o,
    output logic              sclk_o,
    output logic              latch_o
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(SCLK_DIV / 2);

    typedef struct packed {
        scan_mode_e        mode;
        logic [PH_W-1:0]   ph;
        logic [3:0]        bidx;
        logic [WORD_W-1:0] word;
        logic              sdat;
        logic              sclk;
        logic              latch;
    } ser_t;

    ser_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.sdat  = (r_q.mode == MODE_SHIFT) && r_q.word[WORD_W-1];
        r_d.sclk  = (r_q.mode == MODE_SHIFT) && (r_q.ph >= PH_HIGH);
        r_d.latch = (r_q.mode == MODE_LATCH);
        case (r_q.mode)
            MODE_SHIFT: begin
                if (r_q.ph == PH_LAST) begin
                    r_d.ph   = '0;
                    r_d.word = {r_q.word[WORD_W-2:0], 1'b0};
                    if (r_q.bidx == 4'(WORD_W - 1)) r_d.mode = MODE_LATCH;
                    else                            r_d.bidx = r_q.bidx + 1'b1;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            MODE_LATCH: begin
                if (r_q.ph == PH_LAST) begin
                    r_d.ph   = '0;
                    r_d.mode = MODE_IDLE;
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            default: ;
        endcase
        if (load_i) begin
            r_d.mode = MODE_SHIFT;
            r_d.ph   = '0;
            r_d.bidx = '0;
            r_d.word = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{mode: MODE_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign sdat_o  = r_q.sdat;
    assign sclk_o  = r_q.sclk;
    assign latch_o = r_q.latch;

endmodule

// File: rtl/segscan_drv.sv
module segscan_drv
    import segscan_pkg::*;
#(
    parameter int NDIG       = 6,
    parameter int SCLK_DIV   = 4,
    parameter int SLOT_CYC   = 8333,
    parameter bit LSB_FIRST  = 1'b0,
    parameter bit SEG_ON_LOW = 1'b1,
    parameter bit SEL_ON_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDIG*4-1:0] digits_i,
    input  logic [NDIG-1:0]   dp_mask_i,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              ser_latch_o
);

    localparam int DIG_W = (NDIG > 1) ? $clog2(NDIG) : 1;

    logic [DIG_W-1:0]  scan_dig;
    logic              slot_load;
    logic [WORD_W-1:0] slot_word;

    segscan_sequencer #(
        .NDIG     (NDIG),
        .SLOT_CYC (SLOT_CYC),
        .DIG_W    (DIG_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .dig_o  (scan_dig),
        .load_o (slot_load)
    );

    segscan_glyph #(
        .NDIG       (NDIG),
        .DIG_W      (DIG_W),
        .LSB_FIRST  (LSB_FIRST),
        .SEG_ON_LOW (SEG_ON_LOW),
        .SEL_ON_LOW (SEL_ON_LOW)
    ) u_glyph (
        .digits_i  (digits_i),
        .dp_mask_i (dp_mask_i),
        .dig_i     (scan_dig),
        .word_o    (slot_word)
    );

    segscan_serializer #(
        .SCLK_DIV (SCLK_DIV)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (slot_load),
        .word_i  (slot_word),
        .sdat_o  (ser_data_o),
        .sclk_o  (ser_clk_o),
        .latch_o (ser_latch_o)
    );

endmodule

// File: rtl/segscan_chk.sv
module segscan_chk #(
    parameter int NDIG  = 6,
    parameter int DIV   = 4,
    parameter int DIG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk,
    input logic             sdat,
    input logic             latch,
    input logic [DIG_W-1:0] dig
);

    logic       sclk_p;
    logic [4:0] rise_cnt;
    logic [7:0] hi_len;
    logic [7:0] lat_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p   <= 1'b0;
            rise_cnt <= '0;
            hi_len   <= '0;
            lat_len  <= '0;
        end else begin
            sclk_p  <= sclk;
            hi_len  <= sclk  ? hi_len + 1'b1  : 8'd0;
            lat_len <= latch ? lat_len + 1'b1 : 8'd0;
            if (latch)                rise_cnt <= '0;
            else if (sclk && !sclk_p) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R7
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdat));

    // R7
    sclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_len == 8'(DIV / 2));

    // R8
    latch_after_16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch) |-> rise_cnt == 5'd16);

    // R8
    latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch) |-> lat_len == 8'(DIV));

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk && latch));

    // R9
    digit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dig) |->
            dig == (($past(dig) == DIG_W'(NDIG - 1)) ? '0 : $past(dig) + 1'b1));

    // R9
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig < DIG_W'(NDIG));

endmodule

bind segscan_drv segscan_chk #(
    .NDIG  (NDIG),
    .DIV   (SCLK_DIV),
    .DIG_W (DIG_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (ser_clk_o),
    .sdat  (ser_data_o),
    .latch (ser_latch_o),
    .dig   (scan_dig)
);

// File: tb/segscan_drv_tb.sv
`timescale 1ns/1ps
module segscan_drv_tb;

    localparam int NDIG = 6;
    localparam int DIV  = 4;
    localparam int SLOT = 80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NDIG*4-1:0] digits = '0;
    logic [NDIG-1:0]   dp = '0;
    logic [1:0]        sdo, sck, slat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    segscan_drv #(.NDIG(NDIG), .SCLK_DIV(DIV), .SLOT_CYC(SLOT),
                  .LSB_FIRST(1'b0), .SEG_ON_LOW(1'b1), .SEL_ON_LOW(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .digits_i(digits), .dp_mask_i(dp),
        .ser_data_o(sdo[0]), .ser_clk_o(sck[0]), .ser_latch_o(slat[0]));

    segscan_drv #(.NDIG(NDIG), .SCLK_DIV(DIV), .SLOT_CYC(SLOT),
                  .LSB_FIRST(1'b1), .SEG_ON_LOW(1'b0), .SEL_ON_LOW(1'b1)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .digits_i(digits), .dp_mask_i(dp),
        .ser_data_o(sdo[1]), .ser_clk_o(sck[1]), .ser_latch_o(slat[1]));

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] glyph(input logic [3:0] c);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[c];
    endfunction

    function automatic logic [15:0] build_word(input logic [3:0] code, input logic pt,
                                               input int idx, input bit lsb,
                                               input bit segl, input bit sell);
        logic [7:0]  sg, sl;
        logic [15:0] nat, w;
        sg  = {pt, glyph(code)};
        sl  = 8'(1 << idx);
        if (segl) sg = ~sg;
        if (sell) sl = ~sl;
        nat = {sg, sl};
        for (int i = 0; i < 16; i++) w[i] = lsb ? nat[15-i] : nat[i];
        return w;
    endfunction

    // Reference model state
    int          e = 0;
    int          slot_idx = 0;
    logic [15:0] snap [2];
    logic [3:0]  snap_code;
    logic        snap_dp;
    logic [15:0] rx [2];
    logic [1:0]  sck_p = '0, lat_p = '0;
    bit          first_latch = 1'b1;
    bit          mid_flag = 1'b0;

    always @(posedge clk) begin
        if (rst_n) begin
            e = e + 1;
            if ((e - 1) % SLOT == 0) begin
                slot_idx  = ((e - 1) / SLOT) % NDIG;
                snap_code = digits[slot_idx*4 +: 4];
                snap_dp   = dp[slot_idx];
                snap[0]   = build_word(snap_code, snap_dp, slot_idx, 1'b0, 1'b1, 1'b0);
                snap[1]   = build_word(snap_code, snap_dp, slot_idx, 1'b1, 1'b0, 1'b1);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && e > 0 && !done) begin
            int  c;
            bit  es, ed, el;
            c = (e - 1) % SLOT;
            for (int d = 0; d < 2; d++) begin
                es = 0; ed = 0; el = 0;
                if (c >= 1 && c <= 16*DIV) begin
                    es = ((c - 1) % DIV) >= DIV/2;
                    ed = snap[d][15 - (c - 1) / DIV];
                end else if (c > 16*DIV && c <= 17*DIV) begin
                    el = 1;
                end
                check(sck[d] == es,  "R7 shift clock", sck[d], es);
                check(sdo[d] == ed,  "R5 serial data", sdo[d], ed);
                check(slat[d] == el, "R8 latch", slat[d], el);

                // modelled shift-register receiver
                if (sck[d] && !sck_p[d]) rx[d] = {rx[d][14:0], sdo[d]};
                if (slat[d] && !lat_p[d]) begin
                    if (d == 0) begin
                        check(rx[0] == snap[0], "R5 word order", rx[0], snap[0]);
                        check((~rx[0][14:8]) == glyph(snap_code), "R2 segments",
                              ~rx[0][14:8], glyph(snap_code));
                        check((~rx[0][15]) == snap_dp, "R3 decimal point", ~rx[0][15], snap_dp);
                        check(rx[0][7:0] == 8'(1 << slot_idx), "R4/R9 digit select",
                              rx[0][7:0], 8'(1 << slot_idx));
                        if (first_latch) begin
                            check(rx[0][7:0] == 8'h01, "R1 first digit after reset",
                                  rx[0][7:0], 8'h01);
                            first_latch = 1'b0;
                        end
                        if (mid_flag) begin
                            logic [15:0] now_w;
                            now_w = build_word(digits[slot_idx*4 +: 4], dp[slot_idx],
                                               slot_idx, 1'b0, 1'b1, 1'b0);
                            check(rx[0] == snap[0] && rx[0] != now_w,
                                  "R10 word sampled at slot start", rx[0], snap[0]);
                            mid_flag = 1'b0;
                        end
                    end else begin
                        check(rx[1] == snap[1], "R6 polarity and LSB-first", rx[1], snap[1]);
                    end
                end
                sck_p[d] = sck[d];
                lat_p[d] = slat[d];
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check(sdo[d] == 0 && sck[d] == 0 && slat[d] == 0, "R1 outputs in reset",
                  {sdo[d], sck[d], slat[d]}, 0);
        end
        digits = {4'h5, 4'h4, 4'h3, 4'h2, 4'h1, 4'h0};
        dp     = 6'b000001;
        rst_n  = 1'b1;
        repeat (NDIG*SLOT) @(negedge clk);
        digits = {4'hB, 4'hA, 4'h9, 4'h8, 4'h7, 4'h6};
        dp     = 6'b101010;
        repeat (NDIG*SLOT) @(negedge clk);
        digits = {4'h1, 4'h0, 4'hF, 4'hE, 4'hD, 4'hC};
        dp     = 6'b111111;
        repeat (NDIG*SLOT) @(negedge clk);
        digits = {4'h8, 4'h3, 4'h9, 4'h2, 4'h7, 4'h4};
        dp     = 6'b000000;
        repeat (20) @(negedge clk);
        digits   = {NDIG{4'hF}};
        dp       = '1;
        mid_flag = 1'b1;
        repeat (2*NDIG*SLOT - 20) @(negedge clk);
        check(!mid_flag, "R10 mid-slot change observed", mid_flag, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule